// File: doc/BRIEF.md
# Three-Channel Scan Line Capture Buffer

This block sits behind a contact image sensor whose line is split into three segments, each digitised by its own ADC and presented in parallel on a shared sensor clock. When a line-start pulse is seen, the block skips the samples that the converter pipeline has not yet filled, then writes the three segments side by side into three separate line buffers. Each buffer stores exactly one segment length. The first valid sample of each segment goes to address 0, so no sample from the tail of a segment can wrap round to its head.

Once the last sample of every segment is stored, the block drains the buffers as one byte stream. It sends all of segment A, then all of segment B, then all of segment C, each in ascending address order. The stream uses a valid/ready handshake toward a USB FIFO. After the final byte is taken, the block pulses a line-done flag and waits for the next line. A line-start that arrives while a line is still being captured or drained is dropped, and a sticky overrun flag is raised. The whole block runs on the sensor clock, which is at most 8 MHz.

Top module: `scan_line_buffer`

## Requirements
- R1: While reset is low and on the first cycle after it, outValid, lineDone and overrun are all 0.
- R2: A lineStart sampled high in the idle state starts a line, and that edge counts as clock 1. The samples on clocks 1 to 4 are discarded. The sample on clock 5 is stored at address 0 of each buffer and is the first byte that segment emits.
- R3: All three segment buses are stored on the same clocks, 5 through 580, one sample per clock. The sample on clock 580 is the last byte of each segment. Samples on later clocks are not stored.
- R4: outValid rises directly after the clock edge that stores the 576th sample, and stays low before that. Bytes leave in this order: segment A (segSamples bits 7:0), then B (bits 15:8), then C (bits 23:16), each from address 0 upward, 1728 bytes in all.
- R5: The stream advances by one byte only on a clock where outValid and outReady are both 1. Otherwise outValid and outData hold.
- R6: lineDone is 1 for exactly one cycle, right after the handshake that takes the 1728th byte. In that same cycle outValid is 0.
- R7: A lineStart that arrives while the block is skipping, capturing or streaming (including on the cycle of the final handshake) is ignored: the stream content is unchanged. overrun reads 1 on the next cycle.
- R8: overrun stays set until a lineStart is accepted in the idle state, which clears it on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor clock; capture and readout share it |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | Line-start pulse from the sensor |
| segSamples | input | 24 | Three 8-bit ADC samples; segment A in bits 7:0, B in 15:8, C in 23:16 |
| outReady | input | 1 | Downstream FIFO can take a byte |
| outData | output | 8 | Stream byte |
| outValid | output | 1 | outData holds a byte to be taken |
| lineDone | output | 1 | One-cycle pulse after the last byte of a line |
| overrun | output | 1 | Sticky: a line-start was dropped while busy |

## Verification
Two functions can fall in one cycle. The first pair is the final handshake that ends a line and a new line-start pulse. The bench raises lineStart on the very clock that takes byte 1728. It expects that pulse to be ignored, with overrun set, and the next accepted line to clear overrun. In a second case the bench starts a new line in the same cycle that lineDone is high. There the pulse must be accepted, and the following line's bytes must match samples drawn from clock 5 onward. Random stalls on outReady are mixed with these cases, so that a dropped or repeated byte shows up as a data mismatch.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SKIP, ST_CAPT, ST_READ} scanState_t;

  // strobes from control into the datapath
  typedef struct packed {
    logic wrClr;
    logic wrEn;
    logic rdClr;
    logic rdStep;
  } dpStrobe_t;

  // position flags from the datapath back to control
  typedef struct packed {
    logic wrLast;
    logic rdLast;
  } dpFlags_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int SKIP_CLKS = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lineStart,
  input  logic      outReady,
  input  dpFlags_t  flags,
  output dpStrobe_t strb,
  output logic      outValid,
  output logic      lineDone,
  output logic      overrun
);
  localparam int CNT_W = (SKIP_CLKS > 1) ? $clog2(SKIP_CLKS) : 1;

  scanState_t       state;
  logic [CNT_W-1:0] skipCnt;

  initial begin
    if (SKIP_CLKS < 1) $error("SKIP_CLKS must be at least 1");
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      skipCnt  <= '0;
      lineDone <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      lineDone <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (lineStart) begin
            overrun <= 1'b0;
            if (SKIP_CLKS > 1) begin
              state   <= ST_SKIP;
              skipCnt <= CNT_W'(SKIP_CLKS - 1);
            end else begin
              state <= ST_CAPT;
            end
          end
        end
        ST_SKIP: begin
          if (skipCnt == CNT_W'(1)) state <= ST_CAPT;
          else skipCnt <= skipCnt - 1'b1;
        end
        ST_CAPT: begin
          if (flags.wrLast) state <= ST_READ;
        end
        ST_READ: begin
          if (outReady && flags.rdLast) begin
            state    <= ST_IDLE;
            lineDone <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (lineStart && state != ST_IDLE) overrun <= 1'b1;
    end
  end

  always_comb begin
    strb        = '0;
    strb.wrClr  = (state == ST_IDLE) && lineStart;
    strb.wrEn   = (state == ST_CAPT);
    strb.rdClr  = (state == ST_CAPT) && flags.wrLast;
    strb.rdStep = (state == ST_READ) && outReady;
  end

  assign outValid = (state == ST_READ);

  // R7: a pulse while busy raises overrun
  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && state != ST_IDLE) |=> overrun);

  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |=> !lineDone);

  // R6: done only follows an accepted byte, stream idle
  p_done_after_take_r6: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |-> (!outValid && $past(outValid && outReady)));

  // R5: a stalled byte stays offered
  p_valid_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int NUM_SEG = 3,
  parameter int DATA_W  = 8,
  parameter int SEG_LEN = 576
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strb,
  input  logic [NUM_SEG*DATA_W-1:0] segSamples,
  output dpFlags_t                  flags,
  output logic [DATA_W-1:0]         outData
);
  localparam int ADDR_W = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1;
  localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(SEG_LEN - 1);
  localparam logic [SEG_W-1:0]  LAST_SEG  = SEG_W'(NUM_SEG - 1);

  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [SEG_W-1:0]  rdSeg;
  logic [DATA_W-1:0] rdWord [NUM_SEG];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrAddr <= '0;
    end else if (strb.wrClr) begin
      wrAddr <= '0;
    end else if (strb.wrEn && wrAddr != LAST_ADDR) begin
      wrAddr <= wrAddr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.rdClr) begin
      rdAddr <= '0;
      rdSeg  <= '0;
    end else if (strb.rdStep) begin
      if (rdAddr == LAST_ADDR) begin
        rdAddr <= '0;
        rdSeg  <= (rdSeg == LAST_SEG) ? '0 : rdSeg + 1'b1;
      end else begin
        rdAddr <= rdAddr + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic [DATA_W-1:0] segMem [SEG_LEN];
    always_ff @(posedge clk) begin
      if (strb.wrEn) segMem[wrAddr] <= segSamples[g*DATA_W +: DATA_W];
    end
    assign rdWord[g] = segMem[rdAddr];
  end

  always_comb begin
    outData = '0;
    for (int g = 0; g < NUM_SEG; g++) begin
      if (rdSeg == SEG_W'(g)) outData = rdWord[g];
    end
  end

  assign flags.wrLast = (wrAddr == LAST_ADDR);
  assign flags.rdLast = (rdSeg == LAST_SEG) && (rdAddr == LAST_ADDR);

  // R3: writes never leave the buffer
  p_wr_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> (wrAddr <= LAST_ADDR));

  // R5: without a step, clear or write the offered byte is stable
  p_hold_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.rdStep && !strb.rdClr && !strb.wrEn) |=> $stable(outData));

  // R4: end of a segment moves to address 0 of the next one
  p_seg_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStep && !strb.rdClr && rdAddr == LAST_ADDR && rdSeg != LAST_SEG)
      |=> (rdAddr == '0 && rdSeg == SEG_W'($past(rdSeg) + 1'b1)));
endmodule

// File: rtl/scan_line_buffer.sv
module scan_line_buffer
  import scan_pkg::*;
#(
  parameter int NUM_SEG   = 3,
  parameter int DATA_W    = 8,
  parameter int SEG_LEN   = 576,
  parameter int SKIP_CLKS = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      lineStart,
  input  logic [NUM_SEG*DATA_W-1:0] segSamples,
  input  logic                      outReady,
  output logic [DATA_W-1:0]         outData,
  output logic                      outValid,
  output logic                      lineDone,
  output logic                      overrun
);
  dpStrobe_t strb;
  dpFlags_t  flags;

  scan_ctrl #(.SKIP_CLKS(SKIP_CLKS)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lineStart(lineStart),
    .outReady (outReady),
    .flags    (flags),
    .strb     (strb),
    .outValid (outValid),
    .lineDone (lineDone),
    .overrun  (overrun)
  );

  scan_datapath #(.NUM_SEG(NUM_SEG), .DATA_W(DATA_W), .SEG_LEN(SEG_LEN)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .segSamples(segSamples),
    .flags     (flags),
    .outData   (outData)
  );
endmodule

// File: tb/test_scan_line_buffer.sv
module test_scan_line_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SEG    = 3;
  localparam int DATA_W     = 8;
  localparam int SEG_LEN    = 576;
  localparam int SKIP_CLKS  = 4;
  localparam int TOTAL      = NUM_SEG * SEG_LEN;
  localparam int LAST_CLK   = SKIP_CLKS + SEG_LEN;

  logic                      clk = 1'b0;
  logic                      rstN;
  logic                      lineStart;
  logic [NUM_SEG*DATA_W-1:0] segSamples;
  logic                      outReady;
  logic [DATA_W-1:0]         outData;
  logic                      outValid;
  logic                      lineDone;
  logic                      overrun;

  int checks = 0;
  int fails  = 0;
  logic [DATA_W-1:0] expBytes [TOTAL];

  always #(CLK_PERIOD / 2) clk = ~clk;

  scan_line_buffer #(.NUM_SEG(NUM_SEG), .DATA_W(DATA_W), .SEG_LEN(SEG_LEN),
                     .SKIP_CLKS(SKIP_CLKS)) i_scan_line_buffer (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .segSamples(segSamples),
    .outReady(outReady), .outData(outData), .outValid(outValid),
    .lineDone(lineDone), .overrun(overrun)
  );

  // stream position of the sample taken on clock k of segment s
  function automatic int expIndex(int s, int k);
    return s * SEG_LEN + (k - SKIP_CLKS - 1);
  endfunction

  function automatic string tagFor(int idx);
    int pos = idx % SEG_LEN;
    if (pos == 0) return "R2";
    if (pos == SEG_LEN - 1) return "R3";
    return "R4";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idleCycles(int n);
    for (int i = 0; i < n; i++) begin
      lineStart  = 1'b0;
      segSamples = $urandom;
      @(negedge clk);
      check("R4", outValid, 1'b0, "valid while idle");
    end
  endtask

  // Called at a negedge; returns at the negedge where lineDone is expected.
  task automatic runLine(bit randReady, int intrudeK, int intrudeIdx, bit collideEnd);
    bit pendOv = 0;
    int idx = 0;
    lineStart  = 1'b1;
    segSamples = $urandom;
    for (int k = 2; k <= LAST_CLK; k++) begin
      @(negedge clk);
      if (pendOv) begin check("R7", overrun, 1'b1, "overrun after busy start"); pendOv = 0; end
      if (k == 2) begin
        check("R6", lineDone, 1'b0, "lineDone single pulse");
        check("R8", overrun, 1'b0, "overrun cleared by accepted start");
      end
      check("R4", outValid, 1'b0, "valid during capture");
      lineStart  = (k == intrudeK);
      if (k == intrudeK) pendOv = 1;
      segSamples = $urandom;
      if (k > SKIP_CLKS)
        for (int s = 0; s < NUM_SEG; s++)
          expBytes[expIndex(s, k)] = segSamples[s*DATA_W +: DATA_W];
    end
    while (idx < TOTAL) begin
      bit rdy;
      @(negedge clk);
      if (pendOv) begin check("R7", overrun, 1'b1, "overrun after busy start"); pendOv = 0; end
      check("R5", outValid, 1'b1, "valid during readout");
      check(tagFor(idx), outData, expBytes[idx], $sformatf("byte %0d", idx));
      rdy = randReady ? 1'($urandom % 2) : 1'b1;
      if (collideEnd && idx == TOTAL - 1) rdy = 1'b1;
      lineStart = (idx == intrudeIdx && rdy) || (collideEnd && idx == TOTAL - 1);
      if (lineStart) pendOv = 1;
      segSamples = $urandom;
      outReady = rdy;
      if (rdy) idx++;
    end
    @(negedge clk);
    lineStart = 1'b0;
    outReady  = 1'b0;
    if (pendOv) check("R7", overrun, 1'b1, "overrun on final handshake");
    check("R6", lineDone, 1'b1, "lineDone after last byte");
    check("R6", outValid, 1'b0, "valid low at lineDone");
  endtask

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; lineStart = 1'b0; outReady = 1'b0; segSamples = '0;
    repeat (3) @(negedge clk);
    check("R1", outValid, 1'b0, "reset valid");
    check("R1", lineDone, 1'b0, "reset lineDone");
    check("R1", overrun, 1'b0, "reset overrun");
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {outValid, lineDone, overrun}, 3'b000, "after reset");
    runLine(0, -1, -1, 0);          // always ready
    runLine(1, 300, -1, 0);         // back-to-back start, stall, capture intrusion
    idleCycles(5);
    runLine(1, -1, 1000, 0);        // readout intrusion
    runLine(0, -1, -1, 1);          // start on final handshake
    idleCycles(1);
    check("R8", overrun, 1'b1, "overrun sticky while idle");
    runLine(1, 3, 5, 0);            // intrusion during skip and early readout
    idleCycles(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule